// File: doc/BRIEF.md
# Registered Multi-Function ALU

This block is an arithmetic-logic unit for two unsigned operands of `W` bits (8 by default). A 4-bit select input picks one of ten functions: sum, difference, low half of the product, left shift with zero fill, right rotate, AND, OR, XOR, NAND and inversion of the first operand. Shift and rotate take their amount from the second operand. Select codes above the defined ten drive the result to zero.

A parameter, `REGISTERED`, picks how the result is presented. When it is 1, the result is captured on every rising clock edge, and a synchronous active-high reset clears it. When it is 0, the result follows the inputs combinationally, and the clock and reset have no effect.

Top module: `alu8_core`

## Requirements
- R1: Select code 0 gives `(opd_a + opd_b) mod 2^W`.
- R2: Select code 1 gives `(opd_a - opd_b) mod 2^W`.
- R3: Select code 2 gives the low `W` bits of `opd_a * opd_b`.
- R4: Select code 3 gives `opd_a` shifted left by `opd_b` places with zeros filling from bit 0. Any amount of `W` or more gives zero.
- R5: Select code 4 gives `opd_a` rotated right by `opd_b mod W` places, so an amount that is a multiple of `W` returns `opd_a` unchanged.
- R6: Select codes 5, 6, 7 and 8 give bitwise AND, OR, XOR and NAND of the operands.
- R7: Select code 9 gives the bitwise complement of `opd_a`.
- R8: Select codes 10 through 15 give zero.
- R9: With `REGISTERED=1`, `result` takes the function of the inputs present at a rising edge, and holds that value until the next rising edge.
- R10: With `REGISTERED=1`, a high `rst_sync` at a rising edge clears `result` to 0. Raising `rst_sync` between edges leaves `result` unchanged until the next edge.
- R11: With `REGISTERED=0`, `result` follows the inputs with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge; used only when REGISTERED=1 |
| rst_sync | input | 1 | Synchronous reset, active high; used only when REGISTERED=1 |
| opd_a | input | W | First operand |
| opd_b | input | W | Second operand; also the shift or rotate amount |
| op_sel | input | 4 | Function select code |
| result | output | W | Function result |

## Verification
The bench builds two copies at the default width of 8: one with `REGISTERED=1` and one with `REGISTERED=0`, both driven by the same inputs. This lets every vector check the combinational path half a cycle after the inputs change. In the same half cycle, the bench confirms that the registered copy still holds its previous value, and it checks the registered copy again after the edge. At a width of 8, every shift amount on both sides of the overflow boundary can be reached, including rotate amounts that wrap past a multiple of 8. Unused select codes are reached too.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int unsigned SEL_W = 4;

  typedef enum logic [SEL_W-1:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_MUL  = 4'd2,
    OP_SHL  = 4'd3,
    OP_ROR  = 4'd4,
    OP_AND  = 4'd5,
    OP_OR   = 4'd6,
    OP_XOR  = 4'd7,
    OP_NAND = 4'd8,
    OP_NOT  = 4'd9
  } alu_op_e;

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] opd_a,
  input  logic [W-1:0] opd_b,
  output logic [W-1:0] sum,
  output logic [W-1:0] diff,
  output logic [W-1:0] prod
);

  // partial products, each already truncated to W bits
  logic [W-1:0] pp  [W];
  logic [W-1:0] acc [W+1];

  assign sum  = opd_a + opd_b;
  assign diff = opd_a - opd_b;

  assign acc[0] = '0;
  for (genvar k = 0; k < W; k++) begin : g_pp
    assign pp[k]    = opd_b[k] ? (opd_a << k) : '0;
    assign acc[k+1] = acc[k] + pp[k];
  end

  assign prod = acc[W];

endmodule

// File: rtl/alu8_shift.sv
module alu8_shift #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] opd_a,
  input  logic [W-1:0] opd_b,
  output logic [W-1:0] shl,
  output logic [W-1:0] ror
);

  localparam int unsigned SH_W = $clog2(W);

  logic [W-1:0] shl_st [SH_W+1];
  logic [W-1:0] ror_st [SH_W+1];
  logic         shl_over;

  assign shl_st[0] = opd_a;
  assign ror_st[0] = opd_a;

  // log2(W) stages, stage k moves by 2^k when amount bit k is set
  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    localparam int unsigned D = 1 << k;
    assign shl_st[k+1] = opd_b[k] ? {shl_st[k][W-1-D:0], {D{1'b0}}} : shl_st[k];
    assign ror_st[k+1] = opd_b[k] ? {ror_st[k][D-1:0], ror_st[k][W-1:D]} : ror_st[k];
  end

  // any amount bit at or above log2(W) means the shift runs past the width
  assign shl_over = |opd_b[W-1:SH_W];

  assign shl = shl_over ? '0 : shl_st[SH_W];
  assign ror = ror_st[SH_W];

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] opd_a,
  input  logic [W-1:0] opd_b,
  output logic [W-1:0] and_o,
  output logic [W-1:0] or_o,
  output logic [W-1:0] xor_o,
  output logic [W-1:0] nand_o,
  output logic [W-1:0] not_o
);

  assign and_o  = opd_a & opd_b;
  assign or_o   = opd_a | opd_b;
  assign xor_o  = opd_a ^ opd_b;
  assign nand_o = ~and_o;
  assign not_o  = ~opd_a;

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int unsigned W          = 8,
  parameter bit          REGISTERED = 1'b1
) (
  input  logic             clk,
  input  logic             rst_sync,
  input  logic [W-1:0]     opd_a,
  input  logic [W-1:0]     opd_b,
  input  logic [SEL_W-1:0] op_sel,
  output logic [W-1:0]     result
);

  logic [W-1:0] sum, diff, prod;
  logic [W-1:0] shl, ror;
  logic [W-1:0] and_o, or_o, xor_o, nand_o, not_o;
  logic [W-1:0] result_nxt;

  alu8_arith #(.W(W)) u_arith (
    .opd_a (opd_a),
    .opd_b (opd_b),
    .sum   (sum),
    .diff  (diff),
    .prod  (prod)
  );

  alu8_shift #(.W(W)) u_shift (
    .opd_a (opd_a),
    .opd_b (opd_b),
    .shl   (shl),
    .ror   (ror)
  );

  alu8_logic #(.W(W)) u_logic (
    .opd_a  (opd_a),
    .opd_b  (opd_b),
    .and_o  (and_o),
    .or_o   (or_o),
    .xor_o  (xor_o),
    .nand_o (nand_o),
    .not_o  (not_o)
  );

  // function select
  always_comb begin
    case (op_sel)
      OP_ADD:  result_nxt = sum;
      OP_SUB:  result_nxt = diff;
      OP_MUL:  result_nxt = prod;
      OP_SHL:  result_nxt = shl;
      OP_ROR:  result_nxt = ror;
      OP_AND:  result_nxt = and_o;
      OP_OR:   result_nxt = or_o;
      OP_XOR:  result_nxt = xor_o;
      OP_NAND: result_nxt = nand_o;
      OP_NOT:  result_nxt = not_o;
      default: result_nxt = '0;
    endcase
  end

  if (REGISTERED) begin : g_reg
    logic [W-1:0] result_q;
    always_ff @(posedge clk) begin
      if (rst_sync) begin
        result_q <= '0;
      end else begin
        result_q <= result_nxt;
      end
    end
    assign result = result_q;
  end else begin : g_comb
    assign result = result_nxt;
  end

endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk #(
  parameter int unsigned W          = 8,
  parameter bit          REGISTERED = 1'b1
) (
  input logic         clk,
  input logic         rst_sync,
  input logic [W-1:0] opd_a,
  input logic [W-1:0] opd_b,
  input logic [3:0]   op_sel,
  input logic [W-1:0] result
);

  if (REGISTERED) begin : g_chk
    logic primed = 1'b0;
    always @(posedge clk) primed <= 1'b1;

    assert_reset_clears_R10: assert property (@(posedge clk) disable iff (!primed)
      rst_sync |=> (result == '0));

    assert_add_R1: assert property (@(posedge clk) disable iff (rst_sync)
      (op_sel == 4'd0) |=> (W'(result - $past(opd_b)) == $past(opd_a)));

    assert_sub_R2: assert property (@(posedge clk) disable iff (rst_sync)
      (op_sel == 4'd1) |=> (W'(result + $past(opd_b)) == $past(opd_a)));

    assert_shl_over_R4: assert property (@(posedge clk) disable iff (rst_sync)
      (op_sel == 4'd3 && opd_b >= W) |=> (result == '0));

    assert_ror_wrap_R5: assert property (@(posedge clk) disable iff (rst_sync)
      (op_sel == 4'd4 && (opd_b % W) == 0) |=> (result == $past(opd_a)));

    assert_not_R7: assert property (@(posedge clk) disable iff (rst_sync)
      (op_sel == 4'd9) |=> (result == ~$past(opd_a)));

    assert_unused_zero_R8: assert property (@(posedge clk) disable iff (rst_sync)
      (op_sel >= 4'd10) |=> (result == '0));
  end

endmodule

bind alu8_core alu8_core_chk #(.W(W), .REGISTERED(REGISTERED)) u_chk (
  .clk      (clk),
  .rst_sync (rst_sync),
  .opd_a    (opd_a),
  .opd_b    (opd_b),
  .op_sel   (op_sel),
  .result   (result)
);

// File: tb/test_alu8_core.sv
module test_alu8_core;

  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_sync;
  logic [W-1:0] opd_a, opd_b;
  logic [3:0]   op_sel;
  logic [W-1:0] res_reg, res_comb;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  logic [W-1:0] prev_exp;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu8_core #(.W(W), .REGISTERED(1'b1)) i_alu8_core (
    .clk(clk), .rst_sync(rst_sync), .opd_a(opd_a), .opd_b(opd_b),
    .op_sel(op_sel), .result(res_reg)
  );

  alu8_core #(.W(W), .REGISTERED(1'b0)) i_alu8_core_comb (
    .clk(clk), .rst_sync(rst_sync), .opd_a(opd_a), .opd_b(opd_b),
    .op_sel(op_sel), .result(res_comb)
  );

  function automatic logic [W-1:0] ref_alu(logic [W-1:0] a, logic [W-1:0] b, logic [3:0] s);
    logic [2*W-1:0] wide;
    int r;
    case (s)
      4'd0: return W'(a + b);
      4'd1: return W'(a - b);
      4'd2: begin wide = a * b; return wide[W-1:0]; end
      4'd3: return (b >= W) ? '0 : W'(a << b);
      4'd4: begin r = b % W; wide = {a, a} >> r; return wide[W-1:0]; end
      4'd5: return a & b;
      4'd6: return a | b;
      4'd7: return a ^ b;
      4'd8: return ~(a & b);
      4'd9: return ~a;
      default: return '0;
    endcase
  endfunction

  function automatic string tag_of(logic [3:0] s);
    case (s)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3: return "R4";
      4'd4: return "R5";
      4'd5, 4'd6, 4'd7, 4'd8: return "R6";
      4'd9: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (a=%h b=%h s=%0d)", tag, act, exp, opd_a, opd_b, op_sel);
    end
  endtask

  // called just after a rising edge
  task automatic apply(logic [W-1:0] a, logic [W-1:0] b, logic [3:0] s);
    logic [W-1:0] e;
    opd_a = a; opd_b = b; op_sel = s;
    e = ref_alu(a, b, s);
    #(CLK_PERIOD/2 - 1);
    check({tag_of(s), " R11 comb"}, res_comb, e);
    check("R9 hold before edge", res_reg, prev_exp);
    @(posedge clk); #1;
    check({tag_of(s), " R9 reg"}, res_reg, e);
    prev_exp = e;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_sync = 1'b1; opd_a = 8'h5A; opd_b = 8'h33; op_sel = 4'd0;
    repeat (3) @(posedge clk);
    #1;
    check("R10 reset state", res_reg, 8'h00);
    rst_sync = 1'b0;
    prev_exp = 8'h00;

    // directed corners
    apply(8'hFF, 8'h01, 4'd0);
    apply(8'h00, 8'h01, 4'd1);
    apply(8'h10, 8'h10, 4'd2);
    apply(8'hFF, 8'hFF, 4'd2);
    apply(8'h81, 8'd7, 4'd3);
    apply(8'hFF, 8'd8, 4'd3);
    apply(8'hFF, 8'd255, 4'd3);
    apply(8'h96, 8'd0, 4'd3);
    apply(8'h81, 8'd1, 4'd4);
    apply(8'hA5, 8'd8, 4'd4);
    apply(8'h3C, 8'd9, 4'd4);
    apply(8'hC3, 8'd255, 4'd4);
    apply(8'hF0, 8'hCC, 4'd8);
    apply(8'h5A, 8'h00, 4'd9);
    for (int s = 10; s < 16; s++) apply(8'hFF, 8'hFF, 4'(s));

    // reset raised between edges: no change until the edge
    opd_a = 8'h12; opd_b = 8'h34; op_sel = 4'd6;
    @(posedge clk); #1;
    prev_exp = 8'h36;
    check("R9 reg before mid reset", res_reg, prev_exp);
    rst_sync = 1'b1;
    #2;
    check("R10 mid-cycle reset ignored", res_reg, prev_exp);
    @(posedge clk); #1;
    check("R10 cleared at edge", res_reg, 8'h00);
    opd_a = 8'hFF; op_sel = 4'd9;
    @(posedge clk); #1;
    check("R10 held in reset", res_reg, 8'h00);
    rst_sync = 1'b0;
    prev_exp = 8'h00;

    // random vectors
    for (int i = 0; i < 3000; i++) begin
      apply(W'($urandom), (i % 4 == 0) ? W'($urandom_range(0, 17)) : W'($urandom),
            4'($urandom_range(0, 15)));
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule